// File: doc/BRIEF.md
# UART FIFO Control Section

This block is the buffering and FIFO-control part of a 16550-style serial port. It contains a 16-character transmit queue and a 16-character receive queue of 8-bit characters. It also decodes host writes to one control byte, which enables queue mode, flushes either queue, selects a receive threshold and picks the DMA signalling mode. From the queue occupancy it derives a receive-threshold flag and two active-low DMA request outputs: one for the transmit side and one for the receive side.

Each queue has a valid/ready write stream and a valid/ready read stream. On the write side, `*_in_ready` is low while the queue holds 16 characters. Data offered while `*_in_valid` is high and `*_in_ready` is low is discarded and counted as an overrun. On the read side, `*_out_valid` is high while the queue holds at least one character, and a character leaves on a cycle where both valid and ready are high. A read attempted on an empty queue leaves the count as it is, and `*_out_data` keeps showing the last character that left. The serial shifters sit outside this block: they push into the receive queue and pop from the transmit queue. The receiver's character timeout enters on a plain input.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, both counts are 0, `rx_trig` is 0, `txrdy_n` is 0 and `rxrdy_n` is 1.
- R2: Each queue returns characters in the order they were written and holds up to 16 of them. Its count runs from 0 to 16, and `*_in_ready` is 0 exactly when the count is 16.
- R3: A write offered to a full queue is dropped, leaves the count at 16, and raises `*_overrun` for exactly one cycle, in the cycle after the attempt.
- R4: A read attempted on an empty queue leaves the count at 0, and `*_out_data` keeps the value of the last character that left.
- R5: The control byte `cfg_q` is laid out as follows: bits 7:6 hold the threshold select, bit 3 holds the DMA mode, bit 0 holds the queue enable, and bits 5:4 and 2:1 read 0. A write with bit 0 at 0 clears the enable and leaves bits 7:6 and 3 unchanged.
- R6: A write with bits 0 and 1 both set empties the receive queue by the next cycle. It leaves the transmit queue alone, and bit 1 reads back as 0.
- R7: A write with bits 0 and 2 both set empties the transmit queue by the next cycle. It leaves the receive queue alone, and bit 2 reads back as 0.
- R8: The threshold select maps to a receive threshold as follows: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `rx_trig` is 1 exactly when the receive count is at or above the threshold.
- R9: Mode 1 is active when both the enable bit and the DMA mode bit are set. In mode 1, `txrdy_n` is 1 only while the transmit queue holds 16 characters, and 0 otherwise.
- R10: In mode 1, `rxrdy_n` goes to 0 as soon as the receive count reaches the threshold or `rx_timeout` is high. It then stays at 0 until the receive queue is empty.
- R11: Outside mode 1, `txrdy_n` is 0 exactly when the transmit queue is empty, and `rxrdy_n` is 0 exactly when the receive queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte write value |
| cfg_q | output | 8 | Control byte read-back |
| tx_in_valid | input | 1 | Transmit queue write valid |
| tx_in_ready | output | 1 | Transmit queue has room |
| tx_in_data | input | 8 | Transmit character in |
| tx_out_valid | output | 1 | Transmit queue non-empty |
| tx_out_ready | input | 1 | Transmit shifter takes a character |
| tx_out_data | output | 8 | Transmit character out |
| tx_overrun | output | 1 | Transmit write dropped (one-cycle pulse) |
| tx_count | output | 5 | Transmit occupancy 0..16 |
| rx_in_valid | input | 1 | Receive queue write valid |
| rx_in_ready | output | 1 | Receive queue has room |
| rx_in_data | input | 8 | Received character in |
| rx_out_valid | output | 1 | Receive queue non-empty |
| rx_out_ready | input | 1 | Host takes a character |
| rx_out_data | output | 8 | Received character out |
| rx_overrun | output | 1 | Receive write dropped (one-cycle pulse) |
| rx_count | output | 5 | Receive occupancy 0..16 |
| rx_timeout | input | 1 | Receiver character timeout |
| rx_trig | output | 1 | Receive count at or above threshold |
| txrdy_n | output | 1 | Transmit DMA request, active low |
| rxrdy_n | output | 1 | Receive DMA request, active low |

## Verification
A wrong pointer or count shows up on the next cycle. It appears at the count port and at `*_in_ready`, and it also shows as a character out of order on the read stream. A lost or stuck hold state in the receive request logic shows on `rxrdy_n` during the drain that follows a threshold crossing or a timeout. It can rise while characters remain, or stay low once the queue is empty, and the bench sweeps every threshold setting in both signalling modes to expose this. A misdecoded control write shows up one cycle later on `cfg_q`, or as a queue emptied when it should not have been.

// File: rtl/uf_pkg.sv
package uf_pkg;
  typedef struct packed {
    logic [1:0] trig_sel;
    logic       dma_mode;
    logic       fifo_en;
  } uf_cfg_t;

  // threshold for a select code, scaled to the queue depth
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/uf_fifo.sv
module uf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          overrun,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [W-1:0]  last_q;
  logic          do_push, do_pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign do_push   = in_valid && in_ready && !clr;
  assign do_pop    = out_valid && out_ready && !clr;
  assign out_data  = out_valid ? mem[rd_ptr] : last_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      last_q  <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= in_valid && !in_ready && !clr;
      if (clr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
      end else begin
        if (do_push) wr_ptr <= wr_ptr + 1'b1;
        if (do_pop) begin
          rd_ptr <= rd_ptr + 1'b1;
          last_q <= mem[rd_ptr];
        end
        count <= count + CW'(do_push) - CW'(do_pop);
      end
    end
  end

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) && !out_ready && !clr |=> (count == CW'(DEPTH)) && overrun == $past(in_valid));
  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) && !in_valid && !clr |=> (count == '0) && $stable(out_data));
endmodule

// File: rtl/uf_cfg.sv
module uf_cfg
  import uf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] data,
  output uf_cfg_t    cfg,
  output logic       rx_clr,
  output logic       tx_clr,
  output logic [7:0] cfg_q
);
  logic [1:0] unused_rsv;
  assign unused_rsv = data[5:4];

  // flush bits act only in a write that also enables the queues
  assign rx_clr = wr && data[0] && data[1];
  assign tx_clr = wr && data[0] && data[2];
  assign cfg_q  = {cfg.trig_sel, 2'b00, cfg.dma_mode, 2'b00, cfg.fifo_en};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr) begin
      if (data[0]) cfg <= '{trig_sel: data[7:6], dma_mode: data[3], fifo_en: 1'b1};
      else         cfg.fifo_en <= 1'b0;
    end
  end

  // R5
  disable_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !data[0] |=> !cfg.fifo_en && cfg.trig_sel == $past(cfg.trig_sel) && cfg.dma_mode == $past(cfg.dma_mode));
endmodule

// File: rtl/uf_dma_flags.sv
module uf_dma_flags
  import uf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  uf_cfg_t       cfg,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_timeout,
  output logic          rx_trig,
  output logic          txrdy_n,
  output logic          rxrdy_n
);
  logic          mode1, rx_req, rx_held;
  logic [CW-1:0] level;

  assign mode1   = cfg.fifo_en && cfg.dma_mode;
  assign level   = CW'(trig_level(cfg.trig_sel, DEPTH));
  assign rx_trig = (rx_count >= level);
  assign rx_req  = rx_trig || rx_timeout || (rx_held && rx_count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) rx_held <= 1'b0;
    else        rx_held <= mode1 && rx_req;
  end

  assign txrdy_n = mode1 ? (tx_count == CW'(DEPTH)) : (tx_count != '0);
  assign rxrdy_n = mode1 ? !rx_req : (rx_count == '0);

  // R9
  tx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode1 && tx_count < CW'(DEPTH) |-> !txrdy_n);
  // R10
  rx_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode1 && rx_count == '0 && !rx_timeout |-> rxrdy_n);
  // R11
  rx_mode0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode1 |-> rxrdy_n == (rx_count == '0));
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uf_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_data,
  output logic [7:0]    cfg_q,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [W-1:0]  tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [W-1:0]  tx_out_data,
  output logic          tx_overrun,
  output logic [CW-1:0] tx_count,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [W-1:0]  rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [W-1:0]  rx_out_data,
  output logic          rx_overrun,
  output logic [CW-1:0] rx_count,
  input  logic          rx_timeout,
  output logic          rx_trig,
  output logic          txrdy_n,
  output logic          rxrdy_n
);
  uf_cfg_t cfg;
  logic    rx_clr, tx_clr;

  uf_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .data(cfg_data),
    .cfg(cfg), .rx_clr(rx_clr), .tx_clr(tx_clr), .cfg_q(cfg_q)
  );

  uf_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .overrun(tx_overrun), .count(tx_count)
  );

  uf_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .overrun(rx_overrun), .count(rx_count)
  );

  uf_dma_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .tx_count(tx_count), .rx_count(rx_count), .rx_timeout(rx_timeout),
    .rx_trig(rx_trig), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
  );

  // R6
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_data[0] && cfg_data[1] |=> rx_count == '0 && !cfg_q[1]);
  // R7
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_data[0] && cfg_data[2] |=> tx_count == '0 && !cfg_q[2]);
endmodule

// File: tb/sim_uart_fifo_ctrl.sv
module sim_uart_fifo_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0; logic [7:0] cfg_data = 0; logic [7:0] cfg_q;
  logic tx_in_valid = 0, tx_in_ready, tx_out_valid, tx_out_ready = 0, tx_overrun;
  logic [7:0] tx_in_data = 0, tx_out_data; logic [4:0] tx_count;
  logic rx_in_valid = 0, rx_in_ready, rx_out_valid, rx_out_ready = 0, rx_overrun;
  logic [7:0] rx_in_data = 0, rx_out_data; logic [4:0] rx_count;
  logic rx_timeout = 0, rx_trig, txrdy_n, rxrdy_n;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_fifo_ctrl u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_wr = 1; cfg_data = v; step(); cfg_wr = 0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_in_valid = 1; rx_in_data = d; step(); rx_in_valid = 0;
  endtask

  task automatic pop_rx();
    rx_out_ready = 1; step(); rx_out_ready = 0;
  endtask

  task automatic push_tx(input logic [7:0] d);
    tx_in_valid = 1; tx_in_data = d; step(); tx_in_valid = 0;
  endtask

  task automatic pop_tx();
    tx_out_ready = 1; step(); tx_out_ready = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1; step();
    // R1
    chk("R1 cfg_q", cfg_q, 0); chk("R1 tx_count", tx_count, 0); chk("R1 rx_count", rx_count, 0);
    chk("R1 rx_trig", rx_trig, 0); chk("R1 txrdy_n", txrdy_n, 0); chk("R1 rxrdy_n", rxrdy_n, 1);

    // R8 R10 R11 sweep over every threshold, both modes
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        automatic int lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
        automatic bit reached = 0;
        wr_cfg(8'((s << 6) | (m << 3) | 1));
        chk("R5 cfg_q", cfg_q, (s << 6) | (m << 3) | 1);
        for (int n = 1; n <= 16; n++) begin
          push_rx(8'(n * 7 + s));
          if (n >= lvl) reached = 1;
          chk("R2 rx_count", rx_count, n);
          chk("R8 rx_trig", rx_trig, n >= lvl);
          if (m == 1) chk("R10 rxrdy_n fill", rxrdy_n, !(n >= lvl));
          else        chk("R11 rxrdy_n fill", rxrdy_n, 0);
        end
        chk("R2 rx_in_ready full", rx_in_ready, 0);
        push_rx(8'hEE);
        chk("R3 rx_overrun", rx_overrun, 1); chk("R3 rx_count", rx_count, 16);
        step();
        chk("R3 rx_overrun pulse", rx_overrun, 0);
        for (int n = 15; n >= 0; n--) begin
          chk("R2 rx order", rx_out_data, (15 - n + 1) * 7 + s);
          pop_rx();
          chk("R2 rx_count drain", rx_count, n);
          if (m == 1) chk("R10 rxrdy_n drain", rxrdy_n, !(n >= lvl || (reached && n != 0)));
          else        chk("R11 rxrdy_n drain", rxrdy_n, n == 0);
        end
        pop_rx();
        chk("R4 rx_count empty pop", rx_count, 0);
        chk("R4 rx_out_data last", rx_out_data, 16 * 7 + s);
      end
    end

    // R10 timeout path, threshold 4, mode 1
    wr_cfg(8'h49);
    push_rx(8'h11);
    chk("R10 below level", rxrdy_n, 1);
    rx_timeout = 1; #1;
    chk("R10 timeout low", rxrdy_n, 0);
    step(); rx_timeout = 0; #1;
    chk("R10 held after timeout", rxrdy_n, 0);
    pop_rx();
    chk("R10 released on empty", rxrdy_n, 1);

    // R9 R11 transmit side
    for (int m = 0; m < 2; m++) begin
      wr_cfg(8'((m << 3) | 1));
      chk(m ? "R9 txrdy_n empty" : "R11 txrdy_n empty", txrdy_n, 0);
      for (int n = 1; n <= 16; n++) begin
        push_tx(8'(n + 40));
        if (m == 1) chk("R9 txrdy_n", txrdy_n, n == 16);
        else        chk("R11 txrdy_n", txrdy_n, 1);
      end
      push_tx(8'h00);
      chk("R3 tx_overrun", tx_overrun, 1);
      for (int n = 1; n <= 16; n++) begin
        chk("R2 tx order", tx_out_data, n + 40);
        pop_tx();
      end
      chk("R2 tx_count", tx_count, 0);
    end

    // R5 disable keeps other bits
    wr_cfg(8'hC9);
    wr_cfg(8'h00);
    chk("R5 disable keeps", cfg_q, 8'hC8);
    chk("R11 mode0 after disable", txrdy_n, 0);

    // R6 R7 flushes
    wr_cfg(8'h01);
    for (int n = 0; n < 5; n++) begin push_rx(8'(n)); push_tx(8'(n)); end
    wr_cfg(8'h03);
    chk("R6 rx flushed", rx_count, 0); chk("R6 tx kept", tx_count, 5); chk("R6 bit1 reads 0", cfg_q, 1);
    wr_cfg(8'h05);
    chk("R7 tx flushed", tx_count, 0); chk("R7 bit2 reads 0", cfg_q, 1);
    push_rx(8'h5A);
    wr_cfg(8'h04);
    chk("R7 no flush without enable", rx_count, 1);
    chk("R5 enable cleared", cfg_q, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule